// File: doc/BRIEF.md
# Windowed Watchdog Timer With Early-Warning Interrupt

The block is a watchdog counter paced by a slow low-speed clock. The slow clock arrives as a signal and is sampled in the system-clock domain by a short synchronizer. Its rising edges advance the count, and its falling edges supply the half-cycle phase that the warning interrupt needs. Three static option fields set the behaviour. One selects the overflow period, 2^(4+sel) slow cycles by default. One selects how much of the period is open for refresh. One enables a warning interrupt. That interrupt fires at three quarters of the period plus half a slow cycle. The count keeps running after the warning.

Software refreshes the watchdog with a byte write on the system-clock side. The value 0xAC written while the window is open restarts the period. Three events raise a one-cycle reset request: a wrong byte, the correct byte while the window is closed, or the count reaching the full period. The count then starts again from zero.

The controller has six states. SHUT means the window is closed. OPEN means refresh is allowed. ARMED means the three-quarter mark has passed. RING is the one-cycle warning pulse. LATE means the warning has been given. BITE is the one-cycle reset request. The transitions are as follows:
- SHUT to OPEN when the count reaches the opening point.
- OPEN to ARMED when the count reaches three quarters of the period.
- ARMED to RING on the next slow falling edge if the interrupt is enabled, or ARMED to LATE if it is not.
- RING to LATE after one cycle.
- Any running state to BITE on overflow or on an illegal write.
- Any running state to SHUT on a valid refresh.
- BITE to SHUT after one cycle.

Top module: `wwdt_top`

## Requirements
- R1: After reset, rst_req and irq are low and the count is zero.
- R2: Period code p on per_sel gives P = 2^(4+p) slow cycles. Without a refresh, rst_req pulses on the P-th slow rising edge after a restart. That edge is seen in the system domain within three system cycles.
- R3: win_sel code 0 opens half the period. 0xAC written while fewer than P/2 rising edges have been counted raises rst_req. From P/2 on, the write is accepted.
- R4: win_sel code 1 opens three quarters of the period. The window is closed while fewer than P/4 rising edges have been counted.
- R5: win_sel codes 2 and 3 leave the window open for the whole period, including count zero.
- R6: An accepted refresh clears the count. The next overflow comes exactly P rising edges after the write.
- R7: A write of any value other than 0xAC raises rst_req in the following cycle, whatever the count.
- R8: With irq_en high, irq pulses once per period. It pulses on the first slow falling edge after rising edge number 3P/4.
- R9: With irq_en low, irq never rises.
- R10: After a reset request the count restarts from zero and the warning is re-armed. The next overflow comes P rising edges later, with one new warning.
- R11: rst_req and irq are each high for exactly one system cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ls_clk | input | 1 | Low-speed clock, sampled as data |
| per_sel | input | 2 | Overflow period code, P = 2^(4+code) |
| win_sel | input | 2 | Window code: 0 half, 1 three quarters, 2 or 3 full |
| irq_en | input | 1 | Enables the early-warning interrupt |
| wr_en | input | 1 | Refresh register write strobe |
| wr_data | input | 8 | Byte written to the refresh register |
| rst_req | output | 1 | One-cycle internal reset request |
| irq | output | 1 | One-cycle early-warning interrupt |

## Verification
A count that is off by one shows up at the ports as follows. A refresh at the edge of the window is rejected when it should be accepted, or the other way round. The overflow pulse also moves by one whole slow cycle. A fault that leaves the state stuck past the warning shows up one period later, as a missing interrupt in the second period after a reset request. The bench sweeps every refresh position in a 16-cycle period under all four window codes. It also times the overflow and the warning in two back-to-back periods for every period code. Any such fault is therefore caught within at most two periods.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
    localparam logic [7:0] WWDT_KEY = 8'hAC;

    typedef enum logic [1:0] {
        WIN_HALF    = 2'd0,
        WIN_QUARTER = 2'd1,
        WIN_FULL    = 2'd2,
        WIN_FULL_B  = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        ST_SHUT  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_ARMED = 3'd2,
        ST_RING  = 3'd3,
        ST_LATE  = 3'd4,
        ST_BITE  = 3'd5
    } wd_state_e;
endpackage

// File: rtl/wwdt_ls_edge.sv
module wwdt_ls_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_in,
    output logic rise_o,
    output logic fall_o
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its history
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], ls_in};
    end

    assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/wwdt_limits.sv
module wwdt_limits #(
    parameter int BASE_EXP = 4,
    parameter int SEL_W    = 2,
    parameter int CNT_W    = 8
) (
    input  logic [SEL_W-1:0] per_sel,
    input  logic [1:0]       win_sel,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] open_at_o,
    output logic [CNT_W-1:0] warn_at_o
);
    import wwdt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        period_o  = ONE << (BASE_EXP + int'(per_sel));
        warn_at_o = period_o - (period_o >> 2);
        unique case (win_e'(win_sel))
            WIN_HALF:    open_at_o = period_o >> 1;
            WIN_QUARTER: open_at_o = period_o >> 2;
            WIN_FULL:    open_at_o = '0;
            WIN_FULL_B:  open_at_o = '0;
        endcase
    end
endmodule

// File: rtl/wwdt_fsm.sv
module wwdt_fsm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] open_at_i,
    input  logic [CNT_W-1:0] warn_at_i,
    input  logic             irq_en_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    output logic             rst_req_o,
    output logic             irq_o
);
    import wwdt_pkg::*;

    wd_state_e        st, nxt;
    logic [CNT_W-1:0] cnt, cnt_inc, cnt_nx;
    logic             closed, restart, clr;

    assign cnt_inc = cnt + CNT_W'(1);
    assign cnt_nx  = rise_i ? cnt_inc : cnt;
    assign closed  = cnt < open_at_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_SHUT;
        else        st <= nxt;
    end

    // next state: writes win over a same-cycle overflow edge
    always_comb begin
        nxt     = st;
        restart = 1'b0;
        unique case (st)
            ST_BITE: nxt = ST_SHUT;
            default: begin
                if (wr_en_i) begin
                    if (wr_data_i != WWDT_KEY || closed) begin
                        nxt = ST_BITE;
                    end else begin
                        nxt     = ST_SHUT;
                        restart = 1'b1;
                    end
                end else if (rise_i && cnt_inc == period_i) begin
                    nxt = ST_BITE;
                end else begin
                    case (st)
                        ST_SHUT:  if (cnt_nx >= open_at_i) nxt = ST_OPEN;
                        ST_OPEN:  if (cnt_nx >= warn_at_i) nxt = ST_ARMED;
                        ST_ARMED: if (fall_i) nxt = irq_en_i ? ST_RING : ST_LATE;
                        ST_RING:  nxt = ST_LATE;
                        default:  nxt = st;
                    endcase
                end
            end
        endcase
    end

    assign clr = restart || (nxt == ST_BITE) || (st == ST_BITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (rise_i) cnt <= cnt_inc;
    end

    // outputs
    always_comb begin
        rst_req_o = (st == ST_BITE);
        irq_o     = (st == ST_RING);
    end

    // R11
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    // R11
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);
    // R7
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i != WWDT_KEY && !rst_req_o) |=> rst_req_o);
    // R10
    bite_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> cnt == '0);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period_i);
    // R6
    refresh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i == WWDT_KEY && !closed && !rst_req_o)
        |=> (cnt == '0 && !rst_req_o));
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top #(
    parameter int BASE_EXP    = 4,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ls_clk,
    input  logic [SEL_W-1:0] per_sel,
    input  logic [1:0]       win_sel,
    input  logic             irq_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             rst_req,
    output logic             irq
);
    localparam int MAX_EXP = BASE_EXP + (1 << SEL_W) - 1;
    localparam int CNT_W   = MAX_EXP + 1;

    logic             rise, fall;
    logic [CNT_W-1:0] period, open_at, warn_at;

    wwdt_ls_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ls_in  (ls_clk),
        .rise_o (rise),
        .fall_o (fall)
    );

    wwdt_limits #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_lim (
        .per_sel   (per_sel),
        .win_sel   (win_sel),
        .period_o  (period),
        .open_at_o (open_at),
        .warn_at_o (warn_at)
    );

    wwdt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .fall_i    (fall),
        .period_i  (period),
        .open_at_i (open_at),
        .warn_at_i (warn_at),
        .irq_en_i  (irq_en),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rst_req_o (rst_req),
        .irq_o     (irq)
    );
endmodule

// File: tb/wwdt_top_tb.sv
module wwdt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_LS    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ls_clk = 1'b0;
    logic [1:0] per_sel = '0;
    logic [1:0] win_sel = 2'd2;
    logic       irq_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rst_req, irq;

    int n_cmp = 0, n_bad = 0;
    int ls_idx = 0, ls_ph = 0;
    int rst_evt = 0, irq_evt = 0, rst_wide = 0, irq_wide = 0;
    int rst_at = -1, rst_ph = -1, irq_at = -1, irq_ph = -1;
    logic rst_prev = 1'b0, irq_prev = 1'b0;
    bit done = 0;

    wwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .ls_clk(ls_clk), .per_sel(per_sel),
        .win_sel(win_sel), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
        .rst_req(rst_req), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_req && !rst_prev) begin rst_evt++; rst_at = ls_idx; rst_ph = ls_ph; end
        if (rst_req && rst_prev) rst_wide++;
        if (irq && !irq_prev) begin irq_evt++; irq_at = ls_idx; irq_ph = ls_ph; end
        if (irq && irq_prev) irq_wide++;
        rst_prev = rst_req;
        irq_prev = irq;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ls_clk = 1'b0; wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        ls_idx = 0; ls_ph = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_ls(input int n);
        for (int i = 0; i < n; i++) begin
            ls_clk = 1'b1; ls_idx++; ls_ph = 1;
            repeat (HALF_LS) @(negedge clk);
            ls_clk = 1'b0; ls_ph = 0;
            repeat (HALF_LS) @(negedge clk);
        end
    endtask

    task automatic write_byte(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int r0, i0, p, cl;
        logic [7:0] bad_vals [6] = '{8'h00, 8'hAB, 8'hAD, 8'hCA, 8'hFF, 8'h53};

        // R1: reset state
        do_reset();
        chk("R1", "rst_req after reset", int'(rst_req), 0);
        chk("R1", "irq after reset", int'(irq), 0);

        // R2, R8, R10: period and warning timing for every period code
        for (int s = 0; s < 4; s++) begin
            per_sel = 2'(s); win_sel = 2'd2; irq_en = 1'b1;
            p = 1 << (4 + s);
            do_reset();
            r0 = rst_evt; i0 = irq_evt;
            run_ls(p - 1);
            chk("R2", "no overflow before P", rst_evt - r0, 0);
            chk("R8", "one warning", irq_evt - i0, 1);
            chk("R8", "warning slow cycle", irq_at, 3 * p / 4);
            chk("R8", "warning on low phase", irq_ph, 0);
            run_ls(1);
            chk("R2", "overflow at P", rst_evt - r0, 1);
            chk("R2", "overflow edge index", rst_at, p);
            chk("R2", "overflow on high phase", rst_ph, 1);
            run_ls(p);
            chk("R10", "second overflow", rst_evt - r0, 2);
            chk("R10", "second overflow index", rst_at, 2 * p);
            chk("R10", "warning re-armed", irq_evt - i0, 2);
            chk("R10", "second warning index", irq_at, p + 3 * p / 4);
        end

        // R9: interrupt disabled
        per_sel = 2'd0; irq_en = 1'b0;
        do_reset();
        r0 = rst_evt; i0 = irq_evt;
        run_ls(16);
        chk("R9", "no irq when disabled", irq_evt - i0, 0);
        chk("R9", "overflow still occurs", rst_evt - r0, 1);
        irq_en = 1'b1;

        // R3, R4, R5, R6: refresh position sweep for each window code
        for (int w = 0; w < 4; w++) begin
            string tag;
            tag = (w == 0) ? "R3" : (w == 1) ? "R4" : "R5";
            cl  = (w == 0) ? 8 : (w == 1) ? 4 : 0;
            per_sel = 2'd0; win_sel = 2'(w);
            for (int k = 0; k < 16; k++) begin
                do_reset();
                run_ls(k);
                r0 = rst_evt;
                write_byte(8'hAC);
                chk(tag, $sformatf("key at count %0d", k), rst_evt - r0, (k < cl) ? 1 : 0);
                if (k >= cl) begin
                    run_ls(15);
                    chk("R6", "no overflow before P after refresh", rst_evt - r0, 0);
                    run_ls(1);
                    chk("R6", "overflow P after refresh", rst_evt - r0, 1);
                    chk("R6", "overflow index after refresh", rst_at, k + 16);
                end
            end
        end

        // R7, R10: wrong bytes at an open window
        per_sel = 2'd0; win_sel = 2'd2;
        foreach (bad_vals[j]) begin
            do_reset();
            run_ls(2);
            r0 = rst_evt;
            write_byte(bad_vals[j]);
            chk("R7", $sformatf("bad byte %02h", bad_vals[j]), rst_evt - r0, 1);
            run_ls(15);
            chk("R10", "count restarted after bite", rst_evt - r0, 1);
            run_ls(1);
            chk("R10", "overflow P after bite", rst_evt - r0, 2);
        end

        // R11: pulse widths over the whole run
        chk("R11", "rst_req wide cycles", rst_wide, 0);
        chk("R11", "irq wide cycles", irq_wide, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule